// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers single-cycle event pulses from many hardware sources into one 32-bit status word. It drives one combined interrupt line toward a host. A simple register bus carries three words. The status word records which events have occurred, and the host clears its bits by writing ones. The inject word lets software raise any status bit without a hardware event, so that interrupt handlers can be tested. The mask word gates each status bit before the bits are ORed onto the interrupt line.

The mask is active-high for suppression. A mask bit at 1 blocks its source, and a mask bit at 0 lets it through. Out of reset every source is blocked. Only the bit positions that carry a defined event hold a flip-flop. The other status positions read as zero and cannot be raised.

The interrupt line comes from a register, so it follows a change in status or mask one clock later.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Writes and reads use byte offsets on `bus_addr_i`. The status word is at 0x40, the inject word at 0x44 and the mask word at 0x48. Reads are combinational from the address. Reading 0x44 or any unmapped offset returns 0, and a write to an unmapped offset changes nothing.
- R2: An `evt_i` pulse on an implemented bit sets that status bit at the next rising clock edge. The bit then holds until the host clears it.
- R3: The implemented status bits are 31, 30, 29, 28, 27, 24, 22, 20, 19 and 18 (pattern 0xF95C0000). All other status bits always read 0, whether an event pulse or an inject write targets them.
- R4: Writing 1 to a status bit at 0x40 clears that bit. Writing 0 leaves the bit unchanged.
- R5: Writing 1 to a bit of the inject word at 0x44 sets the same implemented status bit at the next edge.
- R6: When an event or an inject write sets a bit in the same cycle that a clear write targets it, the bit ends up set.
- R7: The mask word resets to 0xFFFFFFFF. A write to 0x48 loads all 32 bits, and a read returns them.
- R8: `irq_o` is registered and resets to 0. One clock after any change, it equals the OR over all bits of (status AND NOT mask).
- R9: The status word resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Event pulses, one bit per source |
| bus_wr_i | input | 1 | Write strobe for the register bus |
| bus_addr_i | input | 8 | Byte offset of the register access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Combined interrupt toward the host |

## Verification
The per-bit assertions assume that `evt_i` and the bus write strobe are sampled only at rising edges. They also assume that a clear and a set of the same bit in one cycle is legal input that resolves toward set. The bench drives every input at the falling edge and holds it through exactly one rising edge, so each event pulse and each write acts in a single cycle. It makes events and writes coincide only in the collision scenario, where it checks the set-wins rule directly.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned OFS_W   = 8;

   localparam logic [OFS_W-1:0] OFS_STATUS = 8'h40;
   localparam logic [OFS_W-1:0] OFS_INJECT = 8'h44;
   localparam logic [OFS_W-1:0] OFS_MASK   = 8'h48;

   // Positions that carry a defined event source
   localparam logic [WORD_W-1:0] SRC_PRESENT =
      (32'h1 << 31) | (32'h1 << 30) | (32'h1 << 29) | (32'h1 << 28) |
      (32'h1 << 27) | (32'h1 << 24) | (32'h1 << 22) | (32'h1 << 20) |
      (32'h1 << 19) | (32'h1 << 18);

   typedef struct packed {
      logic clr;
      logic inj;
      logic msk;
   } wr_sel_t;
endpackage

// File: rtl/evt_irq_status_bank.sv
module evt_irq_status_bank #(
   parameter int unsigned         W       = 32,
   parameter logic [W-1:0]        PRESENT = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic         clr_wr_i,
   input  logic         inj_wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] status_o
);
   if (W < 1) begin : g_bad_w
      $error("status bank width must be at least 1");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (PRESENT[b]) begin : g_flop
         logic hit, drop, st_q;
         assign hit  = evt_i[b] | (inj_wr_i & wdata_i[b]);
         assign drop = clr_wr_i & wdata_i[b];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      st_q <= 1'b0;
            else if (hit)    st_q <= 1'b1;
            else if (drop)   st_q <= 1'b0;
         end
         assign status_o[b] = st_q;

         // R2 / R6: any set request lands, even against a clear
         a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i[b] || (inj_wr_i && wdata_i[b])) |=> status_o[b]);
         // R4: clear with no competing set drops the bit
         a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr_i && wdata_i[b] && !evt_i[b] && !inj_wr_i) |=> !status_o[b]);
         // R2 / R4: no request means the bit holds
         a_r2_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt_i[b] && !((inj_wr_i || clr_wr_i) && wdata_i[b])) |=> $stable(status_o[b]));
      end else begin : g_tie
         assign status_o[b] = 1'b0;
      end
   end
endmodule

// File: rtl/evt_irq_mask_reg.sv
module evt_irq_mask_reg #(
   parameter int unsigned  W       = 32,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] mask_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask_o <= RST_VAL;
      else if (wr_i) mask_o <= wdata_i;
   end

   // R7: mask moves only on a write, and then takes the data
   a_r7_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(mask_o));
   a_r7_mask_loads: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (mask_o == $past(wdata_i)));
endmodule

// File: rtl/evt_irq_combine.sv
module evt_irq_combine #(
   parameter int unsigned W       = 32,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] status_i,
   input  logic [W-1:0] mask_i,
   output logic         irq_o
);
   logic live;
   assign live = |(status_i & ~mask_i);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= live;
      end
      // R8: line follows unmasked status one clock later
      a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
         (|(status_i & ~mask_i)) |=> irq_o);
      a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
         !(|(status_i & ~mask_i)) |=> !irq_o);
   end else begin : g_comb
      assign irq_o = live;
   end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
   parameter int unsigned DATA_W   = evt_irq_pkg::WORD_W,
   parameter int unsigned ADDR_W   = evt_irq_pkg::OFS_W,
   parameter logic [DATA_W-1:0] SRC_PRESENT = evt_irq_pkg::SRC_PRESENT,
   parameter bit          REG_OUT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] evt_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o
);
   import evt_irq_pkg::*;

   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_INJECT = ADDR_W'(OFS_INJECT);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);

   if (ADDR_W < 7) begin : g_bad_addr
      $error("address width too small for register offsets");
   end

   wr_sel_t            sel;
   logic [DATA_W-1:0]  status, mask;

   always_comb begin
      sel.clr = bus_wr_i && (bus_addr_i == A_STATUS);
      sel.inj = bus_wr_i && (bus_addr_i == A_INJECT);
      sel.msk = bus_wr_i && (bus_addr_i == A_MASK);
   end

   evt_irq_status_bank #(.W(DATA_W), .PRESENT(SRC_PRESENT)) u_status (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
      .clr_wr_i(sel.clr), .inj_wr_i(sel.inj), .wdata_i(bus_wdata_i),
      .status_o(status));

   evt_irq_mask_reg #(.W(DATA_W), .RST_VAL('1)) u_mask (
      .clk(clk), .rst_n(rst_n), .wr_i(sel.msk), .wdata_i(bus_wdata_i),
      .mask_o(mask));

   evt_irq_combine #(.W(DATA_W), .REG_OUT(REG_OUT)) u_comb (
      .clk(clk), .rst_n(rst_n), .status_i(status), .mask_i(mask),
      .irq_o(irq_o));

   always_comb begin
      if (bus_addr_i == A_STATUS)    bus_rdata_o = status;
      else if (bus_addr_i == A_MASK) bus_rdata_o = mask;
      else                           bus_rdata_o = '0;
   end

   // R3: absent positions never show in status
   a_r3_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & ~SRC_PRESENT) == '0));
   // R1: writes elsewhere leave both registers alone
   a_r1_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && !sel.msk && !sel.clr && !sel.inj && evt_i == '0)
      |=> ($stable(mask) && $stable(status)));
endmodule

// File: tb/evt_irq_ctrl_tb.sv
`timescale 1ns/1ps
module evt_irq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] evt_i = '0;
   logic        bus_wr_i = 1'b0;
   logic [7:0]  bus_addr_i = '0;
   logic [31:0] bus_wdata_i = '0;
   logic [31:0] bus_rdata_o;
   logic        irq_o;
   int checks = 0;
   int errors = 0;

   localparam logic [31:0] PRESENT = 32'hF95C0000;

   always #2.5 clk = ~clk;

   evt_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_wr_i(bus_wr_i),
      .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
      .bus_rdata_o(bus_rdata_o), .irq_o(irq_o));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
      @(posedge clk); @(negedge clk);
      bus_wr_i = 1'b0; bus_wdata_i = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr_i = a; #1; d = bus_rdata_o;
   endtask

   task automatic pulse(input logic [31:0] e);
      evt_i = e;
      @(posedge clk); @(negedge clk);
      evt_i = '0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(8'h40, v); check("R9 status reset", v, 32'h0);
      rd(8'h48, v); check("R7 mask reset", v, 32'hFFFFFFFF);
      check("R8 irq reset", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_event();
      logic [31:0] v;
      pulse(32'h8010_0000);
      rd(8'h40, v); check("R2 event latch", v, 32'h8010_0000);
      repeat (3) @(negedge clk);
      rd(8'h40, v); check("R2 event held", v, 32'h8010_0000);
      check("R8 masked no irq", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_clear();
      logic [31:0] v;
      wr(8'h40, 32'h0);
      rd(8'h40, v); check("R4 write zero keeps", v, 32'h8010_0000);
      wr(8'h40, 32'h8000_0000);
      rd(8'h40, v); check("R4 write one clears", v, 32'h0010_0000);
   endtask

   task automatic t_absent();
      logic [31:0] v;
      pulse(~PRESENT);
      rd(8'h40, v); check("R3 absent event ignored", v, 32'h0010_0000);
      wr(8'h44, ~PRESENT);
      rd(8'h40, v); check("R3 absent inject ignored", v, 32'h0010_0000);
   endtask

   task automatic t_inject();
      logic [31:0] v;
      wr(8'h44, 32'h0140_0000);
      rd(8'h40, v); check("R5 inject sets", v, 32'h0150_0000);
      rd(8'h44, v); check("R1 inject reads zero", v, 32'h0);
      wr(8'h40, 32'hFFFF_FFFF);
      rd(8'h40, v); check("R4 clear all", v, 32'h0);
   endtask

   task automatic t_irq();
      logic [31:0] v;
      wr(8'h48, 32'hFFEF_FFFF);
      rd(8'h48, v); check("R7 mask readback", v, 32'hFFEF_FFFF);
      check("R8 no status no irq", {31'b0, irq_o}, 32'h0);
      pulse(32'h0010_0000);
      check("R8 irq latency low", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      check("R8 irq asserted", {31'b0, irq_o}, 32'h1);
      wr(8'h48, 32'hFFFF_FFFF);
      check("R8 mask latency high", {31'b0, irq_o}, 32'h1);
      @(negedge clk);
      check("R8 mask drops irq", {31'b0, irq_o}, 32'h0);
      wr(8'h48, 32'h0000_0000);
      @(negedge clk);
      check("R8 unmask raises irq", {31'b0, irq_o}, 32'h1);
      wr(8'h40, 32'h0010_0000);
      check("R8 clear latency high", {31'b0, irq_o}, 32'h1);
      @(negedge clk);
      check("R8 clear drops irq", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_collide();
      logic [31:0] v;
      wr(8'h44, 32'h4000_0000);
      evt_i = 32'h0800_0000;
      wr(8'h40, 32'h4800_0000);
      evt_i = '0;
      rd(8'h40, v); check("R6 event beats clear", v, 32'h0800_0000);
      bus_wr_i = 1'b1; bus_addr_i = 8'h40; bus_wdata_i = 32'h0800_0000;
      @(posedge clk); #0.5;
      bus_addr_i = 8'h44;
      @(posedge clk); @(negedge clk);
      bus_wr_i = 1'b0; bus_wdata_i = '0;
      rd(8'h40, v); check("R6 inject after clear", v, 32'h0800_0000);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      wr(8'h4C, 32'hFFFF_FFFF);
      rd(8'h4C, v); check("R1 unmapped reads zero", v, 32'h0);
      rd(8'h40, v); check("R1 unmapped write no status change", v, 32'h0800_0000);
      rd(8'h48, v); check("R1 unmapped write no mask change", v, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_event();
      t_clear();
      t_absent();
      t_inject();
      t_irq();
      t_collide();
      t_unmapped();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule